// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This block decides, one instruction at a time, whether control flow leaves the sequential path. It receives the address of the current instruction, a decoded operation code, the two source register values, the 16-bit relative offset and the 26-bit jump index. It returns the address of the next instruction, a flag that says whether the flow was redirected, and, for the linking forms, a write of the return address into register 31.

Four families are covered. The first compares two registers for equality or inequality. The second tests one register against zero with a signed condition, and can optionally link. The third is a direct jump that stays within the current 256 MB region. The fourth is a register-indirect jump. All results are registered, so they appear one clock after the request. There is no delay slot: the return address and the fall-through address are both the current address plus 4.

Top module: `brj_unit`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `in_valid` low, `out_valid`, `out_taken`, `out_link_we`, `out_misaligned` and `out_next_pc` are all 0.
- R2: A request presented with `in_valid` high produces its result with `out_valid` high exactly one clock later.
- R3: Operation code 1 (equal) is taken when `in_rs` equals `in_rt`. Operation code 2 (not equal) is taken when they differ.
- R4: The zero tests treat `in_rs` as signed. Code 3 is taken when rs >= 0, code 4 when rs > 0, code 5 when rs <= 0, and code 6 when rs < 0. Code 7 uses the rs >= 0 test and code 8 uses the rs < 0 test.
- R5: A taken conditional branch sets the next PC to PC+4 plus the sign-extended offset shifted left by 2. This covers offsets from +32767 down to -32768 instructions.
- R6: When the request is not taken, the next PC is PC+4. This applies to a conditional branch whose test fails, to code 0 (no control transfer), and to the unused codes 13 to 15.
- R7: Codes 9 (jump) and 10 (jump and link) are always taken. Their target is built from three parts, most significant first: the top 4 bits of PC+4, then the 26-bit index, then two zero bits.
- R8: Codes 11 (register jump) and 12 (register jump and link) are always taken, and their next PC is `in_rs` unchanged.
- R9: Codes 7, 8, 10 and 12 raise `out_link_we` with `out_link_idx` = 31 and `out_link_data` = PC+4. Codes 7 and 8 do this whether or not the branch is taken. No other code raises `out_link_we`.
- R10: `out_misaligned` is high only for codes 11 and 12 when bit 1 or bit 0 of `in_rs` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 4 | Operation code (see R3 to R10) |
| in_pc | input | 32 | Address of the current instruction |
| in_rs | input | 32 | First source register value |
| in_rt | input | 32 | Second source register value |
| in_offset | input | 16 | Signed relative offset, in instructions |
| in_index | input | 26 | Direct jump index |
| out_valid | output | 1 | Result present |
| out_taken | output | 1 | Control flow redirected |
| out_next_pc | output | 32 | Address of the next instruction |
| out_link_we | output | 1 | Write the return address |
| out_link_idx | output | 5 | Register index for the link write |
| out_link_data | output | 32 | Return address |
| out_misaligned | output | 1 | Register jump target not word aligned |

## Verification
Some rules can be checked on every cycle, and the assertions cover those. They check the one-cycle valid timing and the all-zero idle outputs. They check that a fall-through result always equals the earlier PC plus 4. They check that every link write targets register 31 with the earlier PC plus 4. They check that the misaligned flag only appears with a target that is not word aligned, and that direct jumps are always taken. Other results can only be shown by the bench scenarios: the exact outcome of each signed zero test at the 0 and -1 boundaries, the extreme forward and backward offsets, the region bits of the direct jump target when PC+4 wraps, and the link write on a linking branch whose test fails.

// File: rtl/brj_pkg.sv
package brj_pkg;

    typedef enum logic [3:0] {
        OP_NONE   = 4'd0,
        OP_BEQ    = 4'd1,
        OP_BNE    = 4'd2,
        OP_BGEZ   = 4'd3,
        OP_BGTZ   = 4'd4,
        OP_BLEZ   = 4'd5,
        OP_BLTZ   = 4'd6,
        OP_BGEZL  = 4'd7,
        OP_BLTZL  = 4'd8,
        OP_JDIR   = 4'd9,
        OP_JDIRL  = 4'd10,
        OP_JREG   = 4'd11,
        OP_JREGL  = 4'd12
    } brj_op_e;

    // Instruction class produced by the decoder
    typedef struct packed {
        logic cond;     // conditional relative branch
        logic jdir;     // direct (region) jump
        logic jreg;     // register-indirect jump
        logic link;     // writes return address
    } brj_class_t;

endpackage

// File: rtl/brj_decode.sv
module brj_decode
    import brj_pkg::*;
(
    input  logic [3:0]  op,
    output brj_class_t  cls
);
    always_comb begin
        cls = '0;
        case (brj_op_e'(op))
            OP_BEQ, OP_BNE, OP_BGEZ, OP_BGTZ, OP_BLEZ, OP_BLTZ: cls.cond = 1'b1;
            OP_BGEZL, OP_BLTZL: begin
                cls.cond = 1'b1;
                cls.link = 1'b1;
            end
            OP_JDIR:  cls.jdir = 1'b1;
            OP_JDIRL: begin
                cls.jdir = 1'b1;
                cls.link = 1'b1;
            end
            OP_JREG:  cls.jreg = 1'b1;
            OP_JREGL: begin
                cls.jreg = 1'b1;
                cls.link = 1'b1;
            end
            default:  cls = '0;
        endcase
    end
endmodule

// File: rtl/brj_cond.sv
module brj_cond
    import brj_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [3:0]      op,
    input  logic [XLEN-1:0] rs,
    input  logic [XLEN-1:0] rt,
    output logic            cond_true
);
    logic rs_neg;
    logic rs_zero;
    logic rs_eq_rt;

    assign rs_neg   = rs[XLEN-1];
    assign rs_zero  = (rs == '0);
    assign rs_eq_rt = (rs == rt);

    always_comb begin
        case (brj_op_e'(op))
            OP_BEQ:             cond_true = rs_eq_rt;
            OP_BNE:             cond_true = !rs_eq_rt;
            OP_BGEZ, OP_BGEZL:  cond_true = !rs_neg;
            OP_BGTZ:            cond_true = !rs_neg && !rs_zero;
            OP_BLEZ:            cond_true = rs_neg || rs_zero;
            OP_BLTZ, OP_BLTZL:  cond_true = rs_neg;
            default:            cond_true = 1'b0;
        endcase
    end
endmodule

// File: rtl/brj_target.sv
module brj_target #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int IDX_W = 26
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  logic [IDX_W-1:0] index,
    input  logic [XLEN-1:0]  rs,
    output logic [XLEN-1:0]  pc_plus4,
    output logic [XLEN-1:0]  rel_tgt,
    output logic [XLEN-1:0]  dir_tgt,
    output logic [XLEN-1:0]  reg_tgt,
    output logic             reg_misaligned
);
    localparam int REGION_W = XLEN - IDX_W - 2;

    logic [XLEN-1:0] off_sext;

    assign pc_plus4 = pc + XLEN'(4);
    assign off_sext = {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset};
    assign rel_tgt  = pc_plus4 + (off_sext << 2);
    assign reg_tgt  = rs;
    assign reg_misaligned = |rs[1:0];

    generate
        if (REGION_W > 0) begin : g_region
            assign dir_tgt = {pc_plus4[XLEN-1 -: REGION_W], index, 2'b00};
        end else begin : g_flat
            assign dir_tgt = XLEN'({index, 2'b00});
        end
    endgenerate
endmodule

// File: rtl/brj_unit.sv
module brj_unit
    import brj_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int OFF_W    = 16,
    parameter int IDX_W    = 26,
    parameter int RIDX_W   = 5,
    parameter int LINK_REG = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        in_op,
    input  logic [XLEN-1:0]   in_pc,
    input  logic [XLEN-1:0]   in_rs,
    input  logic [XLEN-1:0]   in_rt,
    input  logic [OFF_W-1:0]  in_offset,
    input  logic [IDX_W-1:0]  in_index,
    output logic              out_valid,
    output logic              out_taken,
    output logic [XLEN-1:0]   out_next_pc,
    output logic              out_link_we,
    output logic [RIDX_W-1:0] out_link_idx,
    output logic [XLEN-1:0]   out_link_data,
    output logic              out_misaligned
);
    localparam logic [RIDX_W-1:0] LINK_IDX = RIDX_W'(LINK_REG);

    typedef struct packed {
        logic              valid;
        logic              taken;
        logic [XLEN-1:0]   npc;
        logic              we;
        logic [RIDX_W-1:0] lidx;
        logic [XLEN-1:0]   ldata;
        logic              mis;
    } res_t;

    brj_class_t      cls;
    logic            cond_true;
    logic [XLEN-1:0] pc_plus4, rel_tgt, dir_tgt, reg_tgt;
    logic            reg_mis;
    res_t            res_d, res_q;

    brj_decode u_decode (
        .op  (in_op),
        .cls (cls)
    );

    brj_cond #(.XLEN(XLEN)) u_cond (
        .op        (in_op),
        .rs        (in_rs),
        .rt        (in_rt),
        .cond_true (cond_true)
    );

    brj_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_target (
        .pc             (in_pc),
        .offset         (in_offset),
        .index          (in_index),
        .rs             (in_rs),
        .pc_plus4       (pc_plus4),
        .rel_tgt        (rel_tgt),
        .dir_tgt        (dir_tgt),
        .reg_tgt        (reg_tgt),
        .reg_misaligned (reg_mis)
    );

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.valid = 1'b1;
            res_d.npc   = pc_plus4;
            if (cls.cond && cond_true) begin
                res_d.taken = 1'b1;
                res_d.npc   = rel_tgt;
            end
            if (cls.jdir) begin
                res_d.taken = 1'b1;
                res_d.npc   = dir_tgt;
            end
            if (cls.jreg) begin
                res_d.taken = 1'b1;
                res_d.npc   = reg_tgt;
                res_d.mis   = reg_mis;
            end
            if (cls.link) begin
                res_d.we    = 1'b1;
                res_d.lidx  = LINK_IDX;
                res_d.ldata = pc_plus4;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid      = res_q.valid;
    assign out_taken      = res_q.taken;
    assign out_next_pc    = res_q.npc;
    assign out_link_we    = res_q.we;
    assign out_link_idx   = res_q.lidx;
    assign out_link_data  = res_q.ldata;
    assign out_misaligned = res_q.mis;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_taken && !out_link_we && !out_misaligned && out_next_pc == '0));

    // R6
    fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_taken || out_next_pc == $past(in_pc) + XLEN'(4)));

    // R9
    link_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_link_we || (out_link_idx == LINK_IDX && out_link_data == $past(in_pc) + XLEN'(4))));

    // R10
    misalign_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_misaligned |-> (out_taken && out_next_pc[1:0] != 2'b00));

    // R7
    dir_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == 4'd9 || in_op == 4'd10)) |=> out_taken);

endmodule

// File: tb/brj_unit_bench.sv
`timescale 1ns/1ps
module brj_unit_bench;

    typedef struct {
        logic        valid;
        logic        taken;
        logic [31:0] npc;
        logic        we;
        logic [31:0] ldata;
        logic        mis;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [31:0] in_pc = '0, in_rs = '0, in_rt = '0;
    logic [15:0] in_offset = '0;
    logic [25:0] in_index = '0;
    logic        out_valid, out_taken, out_link_we, out_misaligned;
    logic [31:0] out_next_pc, out_link_data;
    logic [4:0]  out_link_idx;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    brj_unit u_brj_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_pc(in_pc), .in_rs(in_rs), .in_rt(in_rt), .in_offset(in_offset),
        .in_index(in_index), .out_valid(out_valid), .out_taken(out_taken),
        .out_next_pc(out_next_pc), .out_link_we(out_link_we),
        .out_link_idx(out_link_idx), .out_link_data(out_link_data),
        .out_misaligned(out_misaligned)
    );

    function automatic exp_t model(bit v, int op, logic [31:0] pc, logic [31:0] rs,
                                   logic [31:0] rt, logic [15:0] off, logic [25:0] idx, string tag);
        exp_t e;
        logic [31:0] p4, rel;
        bit c;
        e.valid = v; e.taken = 0; e.npc = 0; e.we = 0; e.ldata = 0; e.mis = 0; e.tag = tag;
        if (!v) return e;
        p4  = pc + 32'd4;
        rel = p4 + ({{16{off[15]}}, off} * 4);
        e.npc = p4;
        c = 0;
        case (op)
            1: c = (rs == rt);
            2: c = (rs != rt);
            3, 7: c = ($signed(rs) >= 0);
            4: c = ($signed(rs) > 0);
            5: c = ($signed(rs) <= 0);
            6, 8: c = ($signed(rs) < 0);
            default: c = 0;
        endcase
        if (c) begin e.taken = 1; e.npc = rel; end
        if (op == 9 || op == 10) begin e.taken = 1; e.npc = {p4[31:28], idx, 2'b00}; end
        if (op == 11 || op == 12) begin e.taken = 1; e.npc = rs; e.mis = (rs[1:0] != 0); end
        if (op == 7 || op == 8 || op == 10 || op == 12) begin e.we = 1; e.ldata = p4; end
        return e;
    endfunction

    task automatic send(bit v, int op, logic [31:0] pc, logic [31:0] rs, logic [31:0] rt,
                        logic [15:0] off, logic [25:0] idx, string tag);
        @(negedge clk);
        in_valid = v; in_op = 4'(op); in_pc = pc; in_rs = rs; in_rt = rt;
        in_offset = off; in_index = idx;
        sb.push_back(model(v, op, pc, rs, rt, off, idx, tag));
    endtask

    // Monitor: compare each registered result against the queued expectation
    always @(posedge clk) begin
        #1;
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            bit bad;
            e = sb.pop_front();
            checks++;
            bad = (out_valid !== e.valid) || (out_taken !== e.taken) ||
                  (out_next_pc !== e.npc) || (out_link_we !== e.we) ||
                  (out_misaligned !== e.mis) ||
                  (e.we && (out_link_data !== e.ldata || out_link_idx !== 5'd31));
            if (bad) begin
                errors++;
                $display("FAIL %s actual v=%0b t=%0b npc=%h we=%0b li=%0d ld=%h mis=%0b expected v=%0b t=%0b npc=%h we=%0b li=31 ld=%h mis=%0b",
                         e.tag, out_valid, out_taken, out_next_pc, out_link_we, out_link_idx,
                         out_link_data, out_misaligned, e.valid, e.taken, e.npc, e.we, e.ldata, e.mis);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (out_valid !== 0 || out_taken !== 0 || out_link_we !== 0 || out_misaligned !== 0 || out_next_pc !== 0) begin
            errors++;
            $display("FAIL R1 reset actual v=%0b t=%0b npc=%h expected all zero", out_valid, out_taken, out_next_pc);
        end
        rst_n = 1'b1;
        // R3 equal / not equal
        send(1, 1, 32'h0000_1000, 32'h55, 32'h55, 16'd8, 0, "R3 beq taken");
        send(1, 1, 32'h0000_1000, 32'h55, 32'h56, 16'd8, 0, "R3 beq not taken");
        send(1, 2, 32'h0000_2000, 32'h1, 32'h2, 16'hFFFE, 0, "R3 bne taken");
        send(1, 2, 32'h0000_2000, 32'h7, 32'h7, 16'hFFFE, 0, "R3 bne not taken");
        // R4 signed zero tests at 0, -1, +1
        send(1, 3, 32'h100, 32'h0, 0, 16'd4, 0, "R4 bgez zero");
        send(1, 3, 32'h100, 32'hFFFF_FFFF, 0, 16'd4, 0, "R4 bgez neg");
        send(1, 4, 32'h100, 32'h0, 0, 16'd4, 0, "R4 bgtz zero");
        send(1, 4, 32'h100, 32'h7FFF_FFFF, 0, 16'd4, 0, "R4 bgtz max pos");
        send(1, 5, 32'h100, 32'h0, 0, 16'd4, 0, "R4 blez zero");
        send(1, 5, 32'h100, 32'h1, 0, 16'd4, 0, "R4 blez pos");
        send(1, 6, 32'h100, 32'h8000_0000, 0, 16'd4, 0, "R4 bltz min neg");
        send(1, 6, 32'h100, 32'h0, 0, 16'd4, 0, "R4 bltz zero");
        // R5 extreme offsets
        send(1, 1, 32'h0010_0000, 32'h3, 32'h3, 16'h7FFF, 0, "R5 max forward");
        send(1, 1, 32'h0010_0000, 32'h3, 32'h3, 16'h8000, 0, "R5 max backward");
        // R1 idle gap between requests
        send(0, 1, 32'hDEAD_BEEF, 32'h3, 32'h3, 16'h1, 0, "R1 idle");
        // R6 no-op and unused codes
        send(1, 0, 32'h0000_3000, 0, 0, 16'h10, 26'h1, "R6 none");
        send(1, 14, 32'h0000_3000, 0, 0, 16'h10, 26'h1, "R6 unused code");
        // R7 direct jumps, including region wrap of PC+4
        send(1, 9, 32'h4000_0010, 0, 0, 0, 26'h3FF_FFFF, "R7 jump");
        send(1, 9, 32'hFFFF_FFFC, 0, 0, 0, 26'h012_3456, "R7 jump region wrap");
        send(1, 10, 32'h8000_0100, 0, 0, 0, 26'h000_0040, "R7 R9 jump link");
        // R8 register jumps, R10 misaligned
        send(1, 11, 32'h500, 32'h0040_0020, 0, 0, 0, "R8 jr aligned");
        send(1, 12, 32'h600, 32'h0040_0022, 0, 0, 0, "R10 R9 jalr misaligned");
        send(1, 11, 32'h500, 32'h0040_0021, 0, 0, 0, "R10 jr misaligned");
        // R9 linking branches, taken and not taken
        send(1, 7, 32'h700, 32'h5, 0, 16'd2, 0, "R9 bgezal taken");
        send(1, 7, 32'h700, 32'hFFFF_FFF0, 0, 16'd2, 0, "R9 bgezal not taken");
        send(1, 8, 32'h800, 32'hFFFF_FFF0, 0, 16'hFFFF, 0, "R9 bltzal taken");
        send(1, 8, 32'h800, 32'h0, 0, 16'hFFFF, 0, "R9 bltzal not taken");
        // R2 back-to-back then idle
        send(1, 2, 32'h900, 32'h1, 32'h0, 16'd1, 0, "R2 back to back");
        send(0, 0, 0, 0, 0, 0, 0, "R2 R1 idle after");
        send(0, 0, 0, 0, 0, 0, 0, "R1 idle");
        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule